// File: doc/BRIEF.md
# Accumulator CPU register bank with reset-vector load

This block keeps the registers a program can see in a small 8-bit accumulator CPU. These are the accumulator, a 16-bit index pair made of a high byte and a low byte X, a 16-bit stack pointer, a 16-bit program counter and an 8-bit condition code register. On reset some of these registers take fixed values and others keep their contents. After reset the block reads the two-byte start address over a byte-wide read port, taking one byte per cycle. It then signals that the program counter is valid.

Once the start address is loaded, an external sequencer drives one command per cycle on a 4-bit command input. The commands cover:
- program counter step and load;
- stack pointer adjust and partial reinitialise;
- push and pop address generation;
- the unary operations on X.

The accumulator, the CCR and the whole index pair also have direct write strobes. Instruction decode and most flag logic are handled outside this block.

Top module: `cpu_regbank`

## Requirements
- R1: While reset is active and on the first cycle after it, SP reads 0x00FF, H (reg_hx[15:8]) reads 0x00, A reads 0x00, CCR reads 0x68 and vec_done is low.
- R2: Reset leaves X (reg_hx[7:0]) unchanged.
- R3: After reset is released, mem_rd is high with mem_addr 0xFFFE for one cycle, and the byte read there becomes the PC high byte. On the next cycle mem_addr is 0xFFFF, and that byte becomes the PC low byte. vec_done then rises and mem_rd falls.
- R4: Commands applied before vec_done is high have no effect.
- R5: cmd 1 adds one to PC, wrapping from 0xFFFF to 0x0000. cmd 0 changes nothing.
- R6: cmd 2 loads PC from ld_data.
- R7: cmd 3 adds cmd_imm, sign-extended to 16 bits, to SP.
- R8: cmd 4 sets the SP low byte to 0xFF and keeps the SP high byte.
- R9: cmd 5 (push) drives stk_addr with SP in the same cycle, and SP is then decremented by one.
- R10: cmd 6 (pop) drives stk_addr with SP+1 in the same cycle, and SP is then incremented by one.
- R11: The following commands act on the 8 bits of X only and never change H:
  - cmd 7 clears X;
  - cmd 8 increments X;
  - cmd 9 decrements X;
  - cmd 10 inverts X;
  - cmd 11 negates X (two's complement).
- R12: Commands 12 to 15 use the carry, which is CCR bit 0. cmd 12 shifts X left and cmd 13 shifts X right, each filling with 0. cmd 14 rotates X left through carry and cmd 15 rotates X right through carry. In every case the bit moved out of X goes into the carry.
- R13: CCR bits 6 and 5 always read 1. ccr_we writes the other CCR bits from ccr_wdata.
- R14: a_we loads A from a_wdata, and hx_we loads the whole index pair from hx_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_rd | output | 1 | Read strobe for the vector fetch |
| mem_addr | output | 16 | Vector byte address |
| mem_rdata | input | 8 | Byte returned for mem_addr, same cycle |
| vec_done | output | 1 | PC holds the start address; commands are accepted |
| cmd | input | 4 | Register command code |
| cmd_imm | input | 8 | Signed SP adjust value |
| ld_data | input | 16 | PC load value |
| a_we | input | 1 | Accumulator write strobe |
| a_wdata | input | 8 | Accumulator write data |
| hx_we | input | 1 | Index pair write strobe |
| hx_wdata | input | 16 | Index pair write data |
| ccr_we | input | 1 | CCR write strobe |
| ccr_wdata | input | 8 | CCR write data |
| stk_addr | output | 16 | Stack address for push or pop |
| reg_a | output | 8 | Accumulator |
| reg_hx | output | 16 | Index pair H:X |
| reg_sp | output | 16 | Stack pointer |
| reg_pc | output | 16 | Program counter |
| reg_ccr | output | 8 | Condition code register |

## Verification
The embedded assertions check four behaviours on every clock:
- push and pop move SP by exactly one;
- the partial SP reinitialise keeps the SP high byte;
- a PC step adds one;
- the fixed CCR bits stay high and no register moves before the vector fetch ends.

Other behaviours can only be shown by the bench's scenarios. These are:
- the start address assembled from the two bytes;
- X surviving a reset while H is cleared;
- the exact results of the X unary and carry operations;
- the sign extension of the SP adjust.

// File: rtl/cpu_regbank.sv
module cpu_regbank #(
  parameter logic [15:0] SP_INIT  = 16'h00FF,
  parameter logic [15:0] VEC_ADDR = 16'hFFFE,
  parameter logic [7:0]  CCR_INIT = 8'h68
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        vec_done,
  input  logic [3:0]  cmd,
  input  logic [7:0]  cmd_imm,
  input  logic [15:0] ld_data,
  input  logic        a_we,
  input  logic [7:0]  a_wdata,
  input  logic        hx_we,
  input  logic [15:0] hx_wdata,
  input  logic        ccr_we,
  input  logic [7:0]  ccr_wdata,
  output logic [15:0] stk_addr,
  output logic [7:0]  reg_a,
  output logic [15:0] reg_hx,
  output logic [15:0] reg_sp,
  output logic [15:0] reg_pc,
  output logic [7:0]  reg_ccr
);
  localparam logic [3:0] C_PCINC = 4'd1, C_PCLD = 4'd2, C_SPADD = 4'd3, C_SPRST = 4'd4,
                         C_PUSH = 4'd5, C_POP = 4'd6, C_XCLR = 4'd7, C_XINC = 4'd8,
                         C_XDEC = 4'd9, C_XCOM = 4'd10, C_XNEG = 4'd11, C_XLSL = 4'd12,
                         C_XLSR = 4'd13, C_XROL = 4'd14, C_XROR = 4'd15;
  localparam logic [7:0] FIXED1 = 8'h60;

  typedef enum logic [1:0] {F_HI, F_LO, F_RUN} fstate_t;
  fstate_t fst;

  logic [7:0] h_q, x_q, x_nx, ccr_q;
  logic       c_nx, go;

  assign go       = (fst == F_RUN);
  assign vec_done = go;
  assign mem_rd   = !go;
  assign mem_addr = VEC_ADDR | {15'd0, fst == F_LO};
  assign stk_addr = (go && cmd == C_POP) ? reg_sp + 16'd1 : reg_sp;
  assign reg_hx   = {h_q, x_q};
  assign reg_ccr  = ccr_q | FIXED1;

  always_comb begin
    x_nx = x_q;
    c_nx = ccr_q[0];
    case (cmd)
      C_XCLR: x_nx = 8'h00;
      C_XINC: x_nx = x_q + 8'd1;
      C_XDEC: x_nx = x_q - 8'd1;
      C_XCOM: x_nx = ~x_q;
      C_XNEG: x_nx = 8'd0 - x_q;
      C_XLSL: begin x_nx = {x_q[6:0], 1'b0};     c_nx = x_q[7]; end
      C_XLSR: begin x_nx = {1'b0, x_q[7:1]};     c_nx = x_q[0]; end
      C_XROL: begin x_nx = {x_q[6:0], ccr_q[0]}; c_nx = x_q[7]; end
      C_XROR: begin x_nx = {ccr_q[0], x_q[7:1]}; c_nx = x_q[0]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst    <= F_HI;
      reg_pc <= 16'h0000;
      reg_sp <= SP_INIT;
      reg_a  <= 8'h00;
      h_q    <= 8'h00;
      ccr_q  <= CCR_INIT;
    end else if (!go) begin
      if (fst == F_HI) begin
        reg_pc[15:8] <= mem_rdata;
        fst          <= F_LO;
      end else begin
        reg_pc[7:0]  <= mem_rdata;
        fst          <= F_RUN;
      end
    end else begin
      case (cmd)
        C_PCINC: reg_pc <= reg_pc + 16'd1;
        C_PCLD:  reg_pc <= ld_data;
        C_SPADD: reg_sp <= reg_sp + {{8{cmd_imm[7]}}, cmd_imm};
        C_SPRST: reg_sp[7:0] <= 8'hFF;
        C_PUSH:  reg_sp <= reg_sp - 16'd1;
        C_POP:   reg_sp <= reg_sp + 16'd1;
        default: ;
      endcase
      if (a_we) reg_a <= a_wdata;
      if (hx_we) h_q <= hx_wdata[15:8];
      if (ccr_we) ccr_q <= ccr_wdata | FIXED1;
      else if (cmd >= C_XLSL) ccr_q[0] <= c_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && go) begin
      if (hx_we) x_q <= hx_wdata[7:0];
      else x_q <= x_nx;
    end
  end

  // R9
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd == C_PUSH) |=> reg_sp == $past(reg_sp) - 16'd1);
  // R10
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd == C_POP) |=> reg_sp == $past(reg_sp) + 16'd1);
  // R8
  sp_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd == C_SPRST) |=> reg_sp[15:8] == $past(reg_sp[15:8]) && reg_sp[7:0] == 8'hFF);
  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd == C_PCINC) |=> reg_pc == $past(reg_pc) + 16'd1);
  // R13
  ccr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ccr[6:5] == 2'b11);
  // R4
  idle_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(reg_sp) && $stable(reg_a));
endmodule

// File: tb/cpu_regbank_bench.sv
module cpu_regbank_bench;
  logic clk = 0, rst_n = 0;
  logic mem_rd, vec_done;
  logic [15:0] mem_addr, stk_addr, reg_hx, reg_sp, reg_pc, ld_data = 0, hx_wdata = 0;
  logic [7:0] mem_rdata, reg_a, reg_ccr, cmd_imm = 0, a_wdata = 0, ccr_wdata = 0;
  logic [3:0] cmd = 0;
  logic a_we = 0, hx_we = 0, ccr_we = 0;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  assign mem_rdata = (mem_addr == 16'hFFFE) ? 8'h12 : (mem_addr == 16'hFFFF) ? 8'h34 : 8'hEE;

  cpu_regbank u_cpu_regbank (.clk, .rst_n, .mem_rd, .mem_addr, .mem_rdata, .vec_done, .cmd,
    .cmd_imm, .ld_data, .a_we, .a_wdata, .hx_we, .hx_wdata, .ccr_we, .ccr_wdata, .stk_addr,
    .reg_a, .reg_hx, .reg_sp, .reg_pc, .reg_ccr);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [3:0] c, logic [7:0] imm = 0);
    @(negedge clk); cmd = c; cmd_imm = imm;
    @(negedge clk); cmd = 0;
  endtask

  task automatic t_reset_fetch(logic [3:0] held);
    @(negedge clk); rst_n = 0; cmd = held;
    @(negedge clk);
    chk("R1 sp", reg_sp, 16'h00FF);
    chk("R1 h", {8'h0, reg_hx[15:8]}, 16'h0000);
    chk("R1 a", {8'h0, reg_a}, 16'h0000);
    chk("R1 ccr", {8'h0, reg_ccr}, 16'h0068);
    chk("R1 done", {15'h0, vec_done}, 16'h0000);
    rst_n = 1; #1;
    chk("R3 addr hi", mem_addr, 16'hFFFE);
    chk("R3 rd", {15'h0, mem_rd}, 16'h0001);
    @(negedge clk);
    chk("R3 addr lo", mem_addr, 16'hFFFF);
    chk("R4 sp idle", reg_sp, 16'h00FF);
    @(negedge clk);
    cmd = 0;
    chk("R3 pc", reg_pc, 16'h1234);
    chk("R3 done", {14'h0, vec_done, mem_rd}, 16'h0002);
  endtask

  task automatic t_pc;
    run(1); chk("R5 inc", reg_pc, 16'h1235);
    run(0); chk("R5 nop", reg_pc, 16'h1235);
    @(negedge clk); cmd = 2; ld_data = 16'hFFFF;
    @(negedge clk); cmd = 0; chk("R6 load", reg_pc, 16'hFFFF);
    run(1); chk("R5 wrap", reg_pc, 16'h0000);
  endtask

  task automatic t_stack;
    @(negedge clk); cmd = 5; #1 chk("R9 addr", stk_addr, 16'h00FF);
    @(negedge clk); cmd = 0; chk("R9 sp", reg_sp, 16'h00FE);
    cmd = 6; #1 chk("R10 addr", stk_addr, 16'h00FF);
    @(negedge clk); cmd = 0; chk("R10 sp", reg_sp, 16'h00FF);
    run(3, 8'h80); chk("R7 neg", reg_sp, 16'h007F);
    run(3, 8'h10); chk("R7 pos", reg_sp, 16'h008F);
    run(3, 8'h7F); chk("R7 carry", reg_sp, 16'h010E);
    run(4); chk("R8 rsp", reg_sp, 16'h01FF);
  endtask

  task automatic t_x;
    @(negedge clk); hx_we = 1; hx_wdata = 16'hAB05;
    @(negedge clk); hx_we = 0; chk("R14 hx", reg_hx, 16'hAB05);
    run(7); chk("R11 clr", reg_hx, 16'hAB00);
    run(8); run(8); chk("R11 inc", reg_hx, 16'hAB02);
    run(9); chk("R11 dec", reg_hx, 16'hAB01);
    run(10); chk("R11 com", reg_hx, 16'hABFE);
    run(11); chk("R11 neg", reg_hx, 16'hAB02);
    @(negedge clk); hx_we = 1; hx_wdata = 16'h12FF;
    @(negedge clk); hx_we = 0;
    run(8); chk("R11 wrap", reg_hx, 16'h1200);
  endtask

  task automatic t_shift;
    @(negedge clk); ccr_we = 1; ccr_wdata = 8'h00; hx_we = 1; hx_wdata = 16'h0081;
    @(negedge clk); ccr_we = 0; hx_we = 0;
    chk("R13 fixed", {8'h0, reg_ccr}, 16'h0060);
    run(12); chk("R12 lsl", {reg_hx[7:0], 7'h0, reg_ccr[0]}, 16'h0201);
    run(15); chk("R12 ror", {reg_hx[7:0], 7'h0, reg_ccr[0]}, 16'h8100);
    run(14); chk("R12 rol", {reg_hx[7:0], 7'h0, reg_ccr[0]}, 16'h0201);
    run(13); chk("R12 lsr", {reg_hx[7:0], 7'h0, reg_ccr[0]}, 16'h0100);
    @(negedge clk); ccr_we = 1; ccr_wdata = 8'h9F; a_we = 1; a_wdata = 8'h5A;
    @(negedge clk); ccr_we = 0; a_we = 0;
    chk("R13 write", {8'h0, reg_ccr}, 16'h00FF);
    chk("R14 a", {8'h0, reg_a}, 16'h005A);
  endtask

  task automatic t_x_keep;
    @(negedge clk); hx_we = 1; hx_wdata = 16'h77C3;
    @(negedge clk); hx_we = 0;
    t_reset_fetch(4'd8);
    chk("R2 x kept", reg_hx, 16'h00C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_fetch(4'd1);
    t_pc;
    t_stack;
    t_x;
    t_shift;
    t_x_keep;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule